// File: doc/BRIEF.md
# Infrared Timed-Symbol Sequencer

This block plays out a queue of infrared timing symbols. Software pushes 32-bit symbol words through a write port into a 128-entry FIFO. Each word holds three things. The first is a modulate flag, which says whether the symbol is a carrier burst or a silent gap. The second is a 2-bit timebase select. The third is a 10-bit duration, stored as tick count minus one.

The sequencer takes symbols from the FIFO one after another with no idle cycle between them. While a symbol is being played, it drives the modulation request to the carrier generator from that symbol's modulate flag. It counts the symbol's duration on the tick it selected. Four tick inputs supply the timebases: 1 µs, 10 µs, 100 µs and one carrier period. The ticks are generated outside this block.

A low-water threshold sets a pending flag when a symbol taken from the FIFO brings the fill level down to the threshold. If the interrupt is enabled, the block also emits a one-cycle interrupt pulse, so software can refill the FIFO before it runs dry. Clearing the enable input flushes the FIFO and stops the current symbol.

Top module: `irseq_top`

## Requirements
- R1: A word on `wr_data` is queued only when `wr_en` is high, bit 16 of the word is 1 and `enable` is high. A word with bit 16 at 0, or any write while `enable` is low, leaves `level` unchanged.
- R2: Bits 11:10 of a word select which tick input counts its duration: 0 = `tick[0]` (1 µs), 1 = `tick[1]` (10 µs), 2 = `tick[2]` (100 µs), 3 = `tick[3]` (carrier period). Bits 9:0 hold N. The symbol lasts N+1 ticks of the selected input and ignores the other tick inputs.
- R3: While a symbol plays, `mod_req` equals bit 12 of its word (1 = carrier burst, 0 = gap), and `busy` is high.
- R4: The next queued symbol starts in the same cycle that the current one ends, so `busy` stays high without a gap. When the FIFO is empty at the end of a symbol, `busy` and `mod_req` fall to 0 together. The first symbol starts one clock after it is written.
- R5: The FIFO holds 128 entries. A qualified write while the FIFO is full is dropped and sets the sticky `overflow` output.
- R6: `level` reports the number of words waiting in the FIFO, not counting the symbol being played.
- R7: `pending` sets in the cycle that a symbol taken from the FIFO, with no write in that cycle, lowers `level` to `thr`. A rise of `level` through `thr` caused by writes does not set it.
- R8: A high `pend_clr` clears `pending`. When a set and a clear fall in the same cycle, the set wins.
- R9: When `irq_en` is high, `irq` pulses high for exactly one cycle in the cycle that `pending` rises. When `irq_en` is low, `pending` still sets but `irq` stays 0.
- R10: While `enable` is low, the FIFO is emptied, `busy`, `mod_req` and `overflow` are 0, and no playback takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable; low flushes and stops |
| wr_en | input | 1 | Write strobe of the symbol port |
| wr_data | input | 32 | Symbol word |
| tick | input | 4 | Timebase ticks: 1 µs, 10 µs, 100 µs, carrier period |
| thr | input | 8 | Low-water threshold |
| irq_en | input | 1 | Interrupt enable |
| pend_clr | input | 1 | Clear request for the pending flag |
| mod_req | output | 1 | Modulation request to the carrier generator |
| busy | output | 1 | A symbol is being played |
| level | output | 8 | FIFO fill level |
| pending | output | 1 | Threshold pending flag |
| irq | output | 1 | One-cycle interrupt pulse |
| overflow | output | 1 | Sticky write-drop flag |

## Verification
The threshold monitor can set `pending` in the same cycle that software asks to clear it. The bench provokes this collision by holding `pend_clr` high for a whole drain that crosses the threshold. Since the interrupt pulse is produced only when `pending` actually rises, seeing exactly one pulse proves the set won; `pending` then reads 0 because the clear is still held. In the same way, a write and a symbol fetch can fall in one cycle. The bench provokes this by writing back-to-back words while a symbol starts, then checks that `level` stays correct and that no pending flag appears while the FIFO is filling.

// File: rtl/irseq_pkg.sv
package irseq_pkg;
   localparam int DUR_W      = 10;
   localparam int NUM_TB     = 4;
   localparam int TB_W       = $clog2(NUM_TB);
   localparam int WORD_W     = 32;
   localparam int STROBE_POS = 16;
   localparam int MOD_POS    = 12;
   localparam int TB_LSB     = 10;

   typedef struct packed {
      logic            mod;
      logic [TB_W-1:0] tb;
      logic [DUR_W-1:0] dur;
   } sym_t;

   function automatic sym_t unpack_word(input logic [WORD_W-1:0] w);
      sym_t s;
      s.mod = w[MOD_POS];
      s.tb  = w[TB_LSB +: TB_W];
      s.dur = w[DUR_W-1:0];
      return s;
   endfunction
endpackage

// File: rtl/irseq_fifo.sv
module irseq_fifo
   import irseq_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int AW    = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  sym_t             push_sym,
   input  logic             pop,
   output sym_t             head,
   output logic             empty,
   output logic             push_ok,
   output logic [LVL_W-1:0] level,
   output logic             overflow
);
   sym_t           mem [DEPTH];
   logic [AW-1:0]  wr_ptr;
   logic [AW-1:0]  rd_ptr;
   logic           full;
   logic           pop_ok;

   if ((1 << AW) != DEPTH) begin : g_depth_check
      $error("irseq_fifo: DEPTH must be a power of two");
   end

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_sym;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overflow <= 1'b0;
      end else if (flush) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         if (push_ok && !pop_ok)      level <= level + LVL_W'(1);
         else if (pop_ok && !push_ok) level <= level - LVL_W'(1);
         if (push && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/irseq_player.sv
module irseq_player
   import irseq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [NUM_TB-1:0] tick,
   input  sym_t              head,
   input  logic              empty,
   output logic              pop,
   output logic              busy,
   output logic              mod_req
);
   sym_t             cur;
   logic [DUR_W-1:0] cnt;
   logic             tick_sel;
   logic             sym_end;

   always_comb begin
      tick_sel = 1'b0;
      for (int i = 0; i < NUM_TB; i++) begin
         if (cur.tb == TB_W'(i)) tick_sel = tick[i];
      end
   end

   assign sym_end = busy && tick_sel && (cnt == '0);
   assign pop     = enable && !empty && (!busy || sym_end);
   assign mod_req = busy && cur.mod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cur  <= '0;
         cnt  <= '0;
      end else if (!enable) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (pop) begin
         busy <= 1'b1;
         cur  <= head;
         cnt  <= head.dur;
      end else if (sym_end) begin
         busy <= 1'b0;
      end else if (busy && tick_sel) begin
         cnt  <= cnt - DUR_W'(1);
      end
   end
endmodule

// File: rtl/irseq_thresh.sv
module irseq_thresh #(
   parameter int LVL_W = 8,
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_ok,
   input  logic             push_ok,
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   input  logic             irq_en,
   input  logic             pend_clr,
   output logic             pending,
   output logic             irq
);
   localparam int CW = (LVL_W > THR_W ? LVL_W : THR_W) + 1;

   logic set_evt;
   logic pend_nxt;

   assign set_evt  = pop_ok && !push_ok && (CW'(level) == CW'(thr) + CW'(1));
   assign pend_nxt = set_evt ? 1'b1 : (pend_clr ? 1'b0 : pending);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         irq     <= 1'b0;
      end else begin
         pending <= pend_nxt;
         irq     <= pend_nxt && !pending && irq_en;
      end
   end
endmodule

// File: rtl/irseq_top.sv
module irseq_top
   import irseq_pkg::*;
#(
   parameter int DEPTH = 128,
   parameter int THR_W = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [NUM_TB-1:0] tick,
   input  logic [THR_W-1:0]  thr,
   input  logic              irq_en,
   input  logic              pend_clr,
   output logic              mod_req,
   output logic              busy,
   output logic [LVL_W-1:0]  level,
   output logic              pending,
   output logic              irq,
   output logic              overflow
);
   if (THR_W < LVL_W - 1) begin : g_thr_check
      $error("irseq_top: THR_W too narrow for DEPTH");
   end

   sym_t head;
   logic empty;
   logic push;
   logic push_ok;
   logic pop;
   logic unused_bits;

   assign push        = wr_en && wr_data[STROBE_POS] && enable;
   assign unused_bits = ^{wr_data[WORD_W-1:STROBE_POS+1], wr_data[STROBE_POS-1:MOD_POS+1]};

   irseq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (!enable),
      .push     (push),
      .push_sym (unpack_word(wr_data)),
      .pop      (pop),
      .head     (head),
      .empty    (empty),
      .push_ok  (push_ok),
      .level    (level),
      .overflow (overflow)
   );

   irseq_player u_player (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .tick    (tick),
      .head    (head),
      .empty   (empty),
      .pop     (pop),
      .busy    (busy),
      .mod_req (mod_req)
   );

   irseq_thresh #(.LVL_W(LVL_W), .THR_W(THR_W)) u_thresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_ok   (pop),
      .push_ok  (push_ok),
      .level    (level),
      .thr      (thr),
      .irq_en   (irq_en),
      .pend_clr (pend_clr),
      .pending  (pending),
      .irq      (irq)
   );
endmodule

// File: rtl/irseq_chk.sv
module irseq_chk #(
   parameter int DEPTH = 128,
   parameter int LVL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [LVL_W-1:0] level,
   input logic             busy,
   input logic             mod_req,
   input logic             pending,
   input logic             irq,
   input logic             overflow
);
   a_r3_mod_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mod_req |-> busy);

   a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   a_r5_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(level) == LVL_W'(DEPTH));

   a_r6_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && enable) |->
         (level == $past(level) || level == $past(level) + LVL_W'(1) ||
          level + LVL_W'(1) == $past(level)));

   a_r10_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (level == '0 && !busy && !overflow));

   a_r9_irq_with_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pending);

   a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

bind irseq_top irseq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .level    (level),
   .busy     (busy),
   .mod_req  (mod_req),
   .pending  (pending),
   .irq      (irq),
   .overflow (overflow)
);

// File: tb/tb_irseq_top.sv
module tb_irseq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        t1 = 1'b1, t10 = 1'b0, t100 = 1'b0, tc = 1'b0;
   logic [3:0]  tick;
   logic [7:0]  thr = 8'd200;
   logic        irq_en = 1'b0;
   logic        pend_clr = 1'b0;
   logic        mod_req, busy, pending, irq, overflow;
   logic [7:0]  level;

   int checks = 0, errors = 0;
   int busy_cnt = 0, mod_cnt = 0, irq_cnt = 0, cycles = 0;

   assign tick = {tc, t100, t10, t1};

   irseq_top dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
      .tick(tick), .thr(thr), .irq_en(irq_en), .pend_clr(pend_clr),
      .mod_req(mod_req), .busy(busy), .level(level), .pending(pending),
      .irq(irq), .overflow(overflow)
   );

   always #5 clk = ~clk;

   // word: bit16 strobe, bit12 modulate, bits11:10 timebase, bits9:0 ticks-1
   function automatic logic [31:0] mk(input bit stb, input bit m, input int tb, input int dur);
      return (32'(stb) << 16) | (32'(m) << 12) | (32'(tb) << 10) | 32'(dur);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor, tick divider and watchdog
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         cycles++;
         if (busy) busy_cnt++;
         if (mod_req) mod_cnt++;
         if (irq) irq_cnt++;
         div = (div + 1) % 100;
         t10  = (div % 10 == 9);
         t100 = (div == 99);
         if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            finish_run();
         end
      end
   end

   task automatic clr_counts();
      busy_cnt = 0; mod_cnt = 0; irq_cnt = 0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
   endtask

   task automatic push2(input logic [31:0] a, input logic [31:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = a;
      @(negedge clk); wr_data = b;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] exp_mod;
      logic [15:0] exp_busy;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'h0001_1003, 32'h0001_0002, 16'd4,    16'd7},    // burst 4 + gap 3
      '{32'h0001_0000, 32'h0001_1000, 16'd1,    16'd2},    // gap 1 + burst 1
      '{32'h0001_1009, 32'h0000_1005, 16'd10,   16'd10},   // second word has no strobe
      '{32'h0001_1005, 32'h0001_1001, 16'd8,    16'd8},    // two bursts merge
      '{32'h0001_13FF, 32'h0001_0000, 16'd1024, 16'd1025}  // maximum count
   };

   initial begin
      repeat (3) @(negedge clk);
      chk(level == 0 && !busy && !mod_req, "reset R6 R3", int'(level), 0);
      chk(!pending && !irq && !overflow, "reset R7 R9 R5", int'(pending), 0);
      rst_n = 1'b1;
      @(negedge clk); enable = 1'b1;

      // table of symbol pairs, 1 us tick every cycle
      foreach (VECS[i]) begin
         clr_counts();
         push2(VECS[i].a, VECS[i].b);
         wait_idle();
         chk(busy_cnt == int'(VECS[i].exp_busy), "R2 R4 busy length", busy_cnt, int'(VECS[i].exp_busy));
         chk(mod_cnt == int'(VECS[i].exp_mod), "R3 R1 mod length", mod_cnt, int'(VECS[i].exp_mod));
         chk(!mod_req && level == 0, "R4 idle after drain", int'(mod_req), 0);
      end

      // timebase 1 (10 us tick every 10 cycles), 3 ticks
      clr_counts();
      push2(mk(1, 1, 1, 2), mk(0, 0, 0, 0));
      wait_idle();
      chk(busy_cnt >= 20 && busy_cnt <= 31, "R2 10us timebase", busy_cnt, 25);

      // threshold: five 21-tick symbols, thr = 2, interrupt enabled
      thr = 8'd2; irq_en = 1'b1; clr_counts();
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      @(negedge clk); wr_en = 1'b1; wr_data = mk(1, 1, 0, 20);
      @(negedge clk); wr_en = 1'b0;
      chk(level == 4, "R6 level after fill", int'(level), 4);
      chk(!pending, "R7 no set on rising level", int'(pending), 0);
      wait_idle();
      chk(pending, "R7 pending after drain", int'(pending), 1);
      chk(irq_cnt == 1, "R9 one irq pulse", irq_cnt, 1);
      chk(busy_cnt == 105, "R4 five symbols back to back", busy_cnt, 105);
      @(negedge clk); pend_clr = 1'b1;
      @(negedge clk); pend_clr = 1'b0;
      chk(!pending, "R8 clear", int'(pending), 1'b0);

      // same-cycle set and clear: clear held during drain
      clr_counts(); pend_clr = 1'b1;
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      wait_idle();
      chk(irq_cnt == 1, "R8 set wins over clear", irq_cnt, 1);
      chk(!pending, "R8 held clear", int'(pending), 0);
      pend_clr = 1'b0;

      // interrupt disabled
      irq_en = 1'b0; clr_counts();
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      push2(mk(1, 1, 0, 20), mk(1, 0, 0, 20));
      wait_idle();
      chk(pending && irq_cnt == 0, "R9 masked irq", irq_cnt, 0);
      @(negedge clk); pend_clr = 1'b1;
      @(negedge clk); pend_clr = 1'b0;

      // overflow: carrier tick stays low, first symbol stalls
      thr = 8'd200;
      @(negedge clk); wr_en = 1'b1; wr_data = mk(1, 1, 3, 5);
      for (int k = 0; k < 130; k++) @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      chk(level == 128, "R5 depth", int'(level), 128);
      chk(overflow, "R5 sticky overflow", int'(overflow), 1);
      chk(busy && mod_req, "R2 other ticks ignored", int'(busy), 1);
      @(negedge clk);
      chk(overflow && level == 128, "R5 overflow stays", int'(level), 128);

      // disable flushes and stops
      enable = 1'b0;
      @(negedge clk);
      chk(level == 0 && !busy && !mod_req, "R10 flush", int'(level), 0);
      chk(!overflow, "R10 overflow cleared", int'(overflow), 0);
      wr_en = 1'b1; wr_data = mk(1, 1, 0, 3);
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      chk(level == 0 && !busy, "R1 R10 write while disabled", int'(level), 0);
      enable = 1'b1;
      @(negedge clk); wr_en = 1'b1; wr_data = mk(0, 1, 3, 3);
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      chk(level == 0 && !busy, "R1 no strobe ignored", int'(level), 0);

      finish_run();
   end
endmodule